// File: doc/BRIEF.md
# Ethernet Packet Buffer Manager

This block owns the frame memory of a small Ethernet MAC. Two rings of packet slots, one for receive and one for transmit, each with a circular write index and a circular read index, hold whole frames. A host reaches the memory through a 16-bit register bus. It sets an address pointer, moves bytes through a data window that steps the pointer on every access, and issues buffer commands through a command register. The command code sits in write-data bits [7:4].

Received bytes arrive on a byte-stream input. A frame enters the receive ring only if its destination address is either the station address or the all-ones broadcast address, and only if a slot is free. The host builds a transmit frame in the slot at the transmit write index. An enqueue command then stamps a status word into the first two bytes of the frame and sends the payload on a byte-stream output with a valid/ready handshake. When the link is down, an enqueue reports an error and empties both rings. Interrupt status bits are masked into a single interrupt line.

Register selects on `bus_sel`: 0 pointer, 1 data window, 2 command (a read returns the allocated packet number in bits [15:8]), 3 interrupt status, 4 interrupt mask, 5 transmit control, 6 receive control, 7 link status, 8 to 10 station address (low byte first), 11 port status. Interrupt status bits: 0x01 receive, 0x02 transmit, 0x04 transmit empty, 0x08 allocate, 0x20 link error. Register writes ignore `bus_hi_en`.

Top module: `pktbuf_mmu`

## Requirements
- R1: A write to select 2 runs the command coded in write-data bits [7:4]: 2 allocate, 4 and 14 flush, 6 and 8 remove the top receive frame, 12 enqueue. Codes 0, 7, 10 and all undefined codes change no state.
- R2: Allocate sets interrupt status bit 0x08 and loads a running count, wrapped to 7 bits, into bits [15:8] of the select-2 read value. The first allocate after reset loads 0.
- R3: Pointer bit 15 selects the slot at the receive read index (1) or the slot at the transmit write index (0). Bits [10:0] give the byte offset. A data-window access always uses the low byte at the offset, uses the high byte at offset+1 when `bus_hi_en` is set, and advances bits [10:0] by the number of bytes used. Writes while bit 15 is set are dropped.
- R4: Remove (codes 6 and 8) clears receive interrupt bit 0x01 and advances the receive read index when the ring holds a frame. If a frame is still held afterwards, it sets bit 0x01 again. Port status bit 15 reads 1 exactly when the receive ring is empty.
- R5: Enqueue with `link_up` high and transmit-control bit 0 set does four things. It writes status 0x0001, ORed with 0x0040 when destination bytes 4..9 are all 0xFF, into frame bytes 0..1 and into the link-status register. It sets interrupt bits 0x02 and 0x04. It sets port status bit 7. It queues the frame for sending.
- R6: Let L be bytes 2..3 of a queued frame (little-endian, 11 bits). The end is L-1 if bit 5 of byte L-1 is set, otherwise L-2. Bytes from offset 4 up to end-1 are sent in order, with `tx_last` on the final byte. While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R7: Enqueue with `link_up` low does the following. It ORs 0x400 into link status if transmit-control bit 10 is set, and 0x20 if bit 12 is set. It clears transmit-control bit 0 if either of those bits is set. It clears interrupt bit 0x02, sets 0x20, and empties both rings.
- R8: Enqueue with `link_up` high and transmit-control bit 0 clear has no effect.
- R9: A received frame of at least 6 bytes is accepted when receive-control bit 8 is set and its first 6 bytes equal the station address or are all 0xFF. Other frames are dropped. On acceptance, bytes 0..1 are 0, bytes 2..3 hold the byte count, the frame starts at offset 4, and interrupt bit 0x01 is set.
- R10: The receive ring holds at most SLOTS-1 frames. A frame that arrives when the ring is full is dropped.
- R11: Commands 4 and 14, and a receive-control write with bit 15 set, empty both rings. A receive-control write with bit 8 clear empties the receive ring.
- R12: `irq` is high exactly when some interrupt status bit and the matching mask bit are both set.
- R13: Writing 1s to interrupt status clears those bits. After reset, interrupt status and the allocate count are 0 and the port status reads 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 4 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (steps the pointer on data-window reads) |
| bus_hi_en | input | 1 | High byte lane used on data-window access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the select |
| link_up | input | 1 | Link state |
| irq | output | 1 | Masked interrupt |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Last byte of a receive frame |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Last byte of a transmit frame |
| tx_ready | input | 1 | Transmit sink ready |

## Verification
The full receive ring is the state that is hardest to reach, because the ring only fills when enough accepted frames arrive with no remove between them. The bench streams sixteen back-to-back broadcast frames, then drains the ring with remove commands until port status bit 15 rises, and compares the number of removes with SLOTS-1. On the transmit side, a sink that drops `tx_ready` on an irregular pattern forces stalls in the middle of a frame, which exercises the hold rule.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
   typedef enum logic [3:0] {
      CMD_NOP     = 4'd0,
      CMD_ALLOC   = 4'd2,
      CMD_RST_MMU = 4'd4,
      CMD_RM_RX   = 4'd6,
      CMD_RM_TX   = 4'd7,
      CMD_RMREL   = 4'd8,
      CMD_RELEASE = 4'd10,
      CMD_ENQ     = 4'd12,
      CMD_RST_FIFO= 4'd14
   } mmu_cmd_e;

   localparam logic [3:0] SEL_PTR   = 4'd0;
   localparam logic [3:0] SEL_DATA  = 4'd1;
   localparam logic [3:0] SEL_CMD   = 4'd2;
   localparam logic [3:0] SEL_ISTAT = 4'd3;
   localparam logic [3:0] SEL_IMASK = 4'd4;
   localparam logic [3:0] SEL_TXCTL = 4'd5;
   localparam logic [3:0] SEL_RXCTL = 4'd6;
   localparam logic [3:0] SEL_LINK  = 4'd7;
   localparam logic [3:0] SEL_STA0  = 4'd8;
   localparam logic [3:0] SEL_STA1  = 4'd9;
   localparam logic [3:0] SEL_STA2  = 4'd10;
   localparam logic [3:0] SEL_PORT  = 4'd11;
endpackage

// File: rtl/pbm_ring.sv
module pbm_ring #(
   parameter int SLOTS = 16,
   localparam int IW = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic          flush,
   output logic [IW-1:0] in_idx,
   output logic [IW-1:0] out_idx,
   output logic          empty,
   output logic          full,
   output logic          one_left
);
   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("pbm_ring: SLOTS must be a power of two of at least 2");
   end

   assign empty    = (in_idx == out_idx);
   assign full     = (IW'(in_idx + 1'b1) == out_idx);
   assign one_left = (IW'(out_idx + 1'b1) == in_idx);

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         in_idx  <= '0;
         out_idx <= '0;
      end else begin
         if (push && !full)  in_idx  <= in_idx + 1'b1;
         if (pop  && !empty) out_idx <= out_idx + 1'b1;
      end
   end

   // R10: a push into a full ring leaves the write index where it was
   a_r10_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !flush) |=> $stable(in_idx));
   // R4: a pop of an empty ring leaves the read index where it was
   a_r4_empty_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push && !flush) |=> $stable(out_idx) && empty);
endmodule

// File: rtl/pbm_rx_path.sv
module pbm_rx_path #(
   parameter int SLOTS = 16,
   parameter int SLOT_BYTES = 64,
   localparam int IW = $clog2(SLOTS),
   localparam int AW = $clog2(SLOT_BYTES),
   localparam int MW = IW + AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [7:0]    rx_data,
   input  logic          rx_last,
   input  logic [47:0]   station,
   input  logic          rx_en,
   input  logic          full,
   input  logic [IW-1:0] wr_slot,
   output logic          commit,
   input  logic [IW-1:0] rd_slot,
   input  logic [10:0]   rd_addr,
   output logic [7:0]    rd_b0,
   output logic [7:0]    rd_b1
);
   if (SLOT_BYTES < 16 || SLOT_BYTES > 2048 || (SLOT_BYTES & (SLOT_BYTES - 1)) != 0) begin : g_bad_size
      $error("pbm_rx_path: SLOT_BYTES must be a power of two in 16..2048");
   end

   logic [7:0]  mem [SLOTS*SLOT_BYTES];
   logic [10:0] pos;
   logic        sta_ok, bc_ok, sta_n, bc_n, in_dst;
   logic [11:0] wpos;
   logic [10:0] count;
   logic [10:0] rd_addr1;

   assign in_dst = (pos < 11'd6);
   assign sta_n  = sta_ok & (!in_dst || rx_data == station[{pos[2:0], 3'b000} +: 8]);
   assign bc_n   = bc_ok  & (!in_dst || rx_data == 8'hFF);
   assign commit = rx_valid && rx_last && rx_en && !full && (pos >= 11'd5) && (sta_n || bc_n);
   assign count  = pos + 11'd1;
   assign wpos   = {1'b0, pos} + 12'd4;
   assign rd_addr1 = rd_addr + 11'd1;
   assign rd_b0  = mem[{rd_slot, rd_addr[AW-1:0]}];
   assign rd_b1  = mem[{rd_slot, rd_addr1[AW-1:0]}];

   always_ff @(posedge clk) begin
      if (rx_valid && wpos < 12'(SLOT_BYTES))
         mem[MW'({wr_slot, wpos[AW-1:0]})] <= rx_data;
      if (commit) begin
         mem[{wr_slot, AW'(0)}] <= 8'h00;
         mem[{wr_slot, AW'(1)}] <= 8'h00;
         mem[{wr_slot, AW'(2)}] <= count[7:0];
         mem[{wr_slot, AW'(3)}] <= {5'b0, count[10:8]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos    <= '0;
         sta_ok <= 1'b1;
         bc_ok  <= 1'b1;
      end else if (rx_valid) begin
         if (rx_last) begin
            pos    <= '0;
            sta_ok <= 1'b1;
            bc_ok  <= 1'b1;
         end else begin
            if (pos != 11'h7FF) pos <= pos + 11'd1;
            sta_ok <= sta_n;
            bc_ok  <= bc_n;
         end
      end
   end

   // R10: no frame is committed while the ring reports full
   a_r10_no_commit_full: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !commit);
endmodule

// File: rtl/pbm_tx_path.sv
module pbm_tx_path #(
   parameter int SLOTS = 16,
   parameter int SLOT_BYTES = 64,
   localparam int IW = $clog2(SLOTS),
   localparam int AW = $clog2(SLOT_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [IW-1:0] wr_slot,
   input  logic          bus_we,
   input  logic          bus_hi,
   input  logic [10:0]   bus_addr,
   input  logic [15:0]   bus_wdata,
   output logic [7:0]    rd_b0,
   output logic [7:0]    rd_b1,
   input  logic          stat_we,
   input  logic [15:0]   stat_val,
   output logic          bcast,
   input  logic          pend,
   input  logic [IW-1:0] out_slot,
   output logic          pop,
   output logic          tx_valid,
   output logic [7:0]    tx_data,
   output logic          tx_last,
   input  logic          tx_ready
);
   logic [7:0]  mem [SLOTS*SLOT_BYTES];
   logic [10:0] addr1, raw, rawm1, eff, pos, endp;
   logic        run, go, lastb5, at_end;

   assign addr1 = bus_addr + 11'd1;
   assign rd_b0 = mem[{wr_slot, bus_addr[AW-1:0]}];
   assign rd_b1 = mem[{wr_slot, addr1[AW-1:0]}];

   always_comb begin
      bcast = 1'b1;
      for (int k = 4; k < 10; k++)
         bcast &= (mem[{wr_slot, AW'(k)}] == 8'hFF);
   end

   always_ff @(posedge clk) begin
      if (stat_we) begin
         mem[{wr_slot, AW'(0)}] <= stat_val[7:0];
         mem[{wr_slot, AW'(1)}] <= stat_val[15:8];
      end else if (bus_we) begin
         mem[{wr_slot, bus_addr[AW-1:0]}] <= bus_wdata[7:0];
         if (bus_hi) mem[{wr_slot, addr1[AW-1:0]}] <= bus_wdata[15:8];
      end
   end

   // length decode of the slot at the head of the ring
   assign raw    = {mem[{out_slot, AW'(3)}][2:0], mem[{out_slot, AW'(2)}]};
   assign rawm1  = raw - 11'd1;
   assign lastb5 = mem[{out_slot, rawm1[AW-1:0]}][5];
   assign eff    = lastb5 ? raw - 11'd1 : raw - 11'd2;
   assign go     = (raw > 11'd4) && (eff > 11'd4);
   assign at_end = (pos == endp - 11'd1);

   assign tx_valid = run;
   assign tx_data  = mem[{out_slot, pos[AW-1:0]}];
   assign tx_last  = run && at_end;
   assign pop      = !flush && ((!run && pend && !go) || (run && tx_ready && at_end));

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         run  <= 1'b0;
         pos  <= '0;
         endp <= '0;
      end else if (!run) begin
         if (pend && go) begin
            run  <= 1'b1;
            pos  <= 11'd4;
            endp <= eff;
         end
      end else if (tx_ready) begin
         if (at_end) run <= 1'b0;
         else        pos <= pos + 11'd1;
      end
   end

   // R6: a stalled byte stays on the output until accepted
   a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !flush) |=> tx_valid && $stable(tx_data));
endmodule

// File: rtl/pktbuf_mmu.sv
module pktbuf_mmu
   import pbm_pkg::*;
#(
   parameter int SLOTS = 16,
   parameter int SLOT_BYTES = 64,
   localparam int IW = $clog2(SLOTS)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  bus_sel,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic        bus_hi_en,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   input  logic        link_up,
   output logic        irq,
   input  logic        rx_valid,
   input  logic [7:0]  rx_data,
   input  logic        rx_last,
   output logic        tx_valid,
   output logic [7:0]  tx_data,
   output logic        tx_last,
   input  logic        tx_ready
);
   logic [15:0] ptr, txctl, rxctl, eph, sta0, sta1, sta2;
   logic [7:0]  istat, imask, pnr_hi;
   logic [6:0]  alloc_cnt;
   logic        port_txdone;

   logic        cmd_we, do_alloc, do_reset, do_rm, do_enq, enq_down, enq_send;
   logic        rxctl_we, flush_all, flush_rx, dp_acc;
   logic [3:0]  code;

   logic [IW-1:0] rx_in, rx_out, tx_in, tx_out;
   logic          rx_empty, rx_full, rx_one, tx_empty, tx_full, tx_one;
   logic          rx_commit, tx_pop, bcast;
   logic [7:0]    rx_b0, rx_b1, tx_b0, tx_b1;

   assign code     = bus_wdata[7:4];
   assign cmd_we   = bus_wr && bus_sel == SEL_CMD;
   assign do_alloc = cmd_we && code == CMD_ALLOC;
   assign do_reset = cmd_we && (code == CMD_RST_MMU || code == CMD_RST_FIFO);
   assign do_rm    = cmd_we && (code == CMD_RM_RX || code == CMD_RMREL);
   assign do_enq   = cmd_we && code == CMD_ENQ;
   assign enq_down = do_enq && !link_up;
   assign enq_send = do_enq && link_up && txctl[0];
   assign rxctl_we = bus_wr && bus_sel == SEL_RXCTL;
   assign flush_all = do_reset || enq_down || (rxctl_we && bus_wdata[15]);
   assign flush_rx  = flush_all || (rxctl_we && !bus_wdata[8]);
   assign dp_acc    = bus_sel == SEL_DATA && (bus_wr || bus_rd);

   pbm_ring #(.SLOTS(SLOTS)) u_rx_ring (
      .clk, .rst_n, .push(rx_commit), .pop(do_rm), .flush(flush_rx),
      .in_idx(rx_in), .out_idx(rx_out), .empty(rx_empty), .full(rx_full), .one_left(rx_one));

   pbm_ring #(.SLOTS(SLOTS)) u_tx_ring (
      .clk, .rst_n, .push(enq_send), .pop(tx_pop), .flush(flush_all),
      .in_idx(tx_in), .out_idx(tx_out), .empty(tx_empty), .full(tx_full), .one_left(tx_one));

   pbm_rx_path #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_rx (
      .clk, .rst_n, .rx_valid, .rx_data, .rx_last,
      .station({sta2, sta1, sta0}), .rx_en(rxctl[8]), .full(rx_full), .wr_slot(rx_in),
      .commit(rx_commit), .rd_slot(rx_out), .rd_addr(ptr[10:0]), .rd_b0(rx_b0), .rd_b1(rx_b1));

   pbm_tx_path #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_tx (
      .clk, .rst_n, .flush(flush_all), .wr_slot(tx_in),
      .bus_we(bus_wr && bus_sel == SEL_DATA && !ptr[15]), .bus_hi(bus_hi_en),
      .bus_addr(ptr[10:0]), .bus_wdata, .rd_b0(tx_b0), .rd_b1(tx_b1),
      .stat_we(enq_send), .stat_val({9'b0, bcast, 6'b000001}), .bcast,
      .pend(!tx_empty), .out_slot(tx_out), .pop(tx_pop),
      .tx_valid, .tx_data, .tx_last, .tx_ready);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0; txctl <= '0; rxctl <= '0; eph <= '0;
         sta0 <= '0; sta1 <= '0; sta2 <= '0;
         istat <= '0; imask <= '0; pnr_hi <= '0; alloc_cnt <= '0; port_txdone <= 1'b0;
      end else begin
         if (bus_wr) begin
            case (bus_sel)
               SEL_PTR:   ptr   <= bus_wdata;
               SEL_IMASK: imask <= bus_wdata[7:0];
               SEL_RXCTL: rxctl <= bus_wdata;
               SEL_STA0:  sta0  <= bus_wdata;
               SEL_STA1:  sta1  <= bus_wdata;
               SEL_STA2:  sta2  <= bus_wdata;
               default: ;
            endcase
         end
         if (dp_acc) ptr[10:0] <= ptr[10:0] + (bus_hi_en ? 11'd2 : 11'd1);

         if (bus_wr && bus_sel == SEL_TXCTL)            txctl    <= bus_wdata;
         else if (enq_down && (txctl[10] || txctl[12])) txctl[0] <= 1'b0;

         if (enq_send) begin
            eph <= {9'b0, bcast, 6'b000001};
            port_txdone <= 1'b1;
         end else if (enq_down) begin
            eph[10] <= eph[10] | txctl[10];
            eph[5]  <= eph[5]  | txctl[12];
         end

         if (do_alloc) begin
            pnr_hi    <= {1'b0, alloc_cnt};
            alloc_cnt <= alloc_cnt + 7'd1;
         end

         begin : istat_upd
            logic [7:0] nx;
            nx = istat;
            if (bus_wr && bus_sel == SEL_ISTAT) nx = nx & ~bus_wdata[7:0];
            if (do_rm) begin
               nx[0] = 1'b0;
               if (!rx_empty && !rx_one) nx[0] = 1'b1;
            end
            if (enq_down) begin
               nx[1] = 1'b0;
               nx[5] = 1'b1;
            end
            if (enq_send)  nx[2:1] = 2'b11;
            if (do_alloc)  nx[3]   = 1'b1;
            if (rx_commit) nx[0]   = 1'b1;
            istat <= nx;
         end
      end
   end

   assign irq = |(istat & imask);

   always_comb begin
      case (bus_sel)
         SEL_PTR:   bus_rdata = ptr;
         SEL_DATA:  bus_rdata = ptr[15] ? {bus_hi_en ? rx_b1 : 8'h00, rx_b0}
                                        : {bus_hi_en ? tx_b1 : 8'h00, tx_b0};
         SEL_CMD:   bus_rdata = {pnr_hi, 8'h00};
         SEL_ISTAT: bus_rdata = {8'h00, istat};
         SEL_IMASK: bus_rdata = {8'h00, imask};
         SEL_TXCTL: bus_rdata = txctl;
         SEL_RXCTL: bus_rdata = rxctl;
         SEL_LINK:  bus_rdata = eph;
         SEL_STA0:  bus_rdata = sta0;
         SEL_STA1:  bus_rdata = sta1;
         SEL_STA2:  bus_rdata = sta2;
         SEL_PORT:  bus_rdata = {rx_empty, 7'b0, port_txdone, 7'b0};
         default:   bus_rdata = 16'h0000;
      endcase
   end

   // R2: an allocate command raises the allocate flag
   a_r2_alloc_flag: assert property (@(posedge clk) disable iff (!rst_n)
      do_alloc |=> istat[3]);
   // R7: an enqueue with the link down leaves both rings empty
   a_r7_down_flush: assert property (@(posedge clk) disable iff (!rst_n)
      enq_down |=> rx_empty && tx_empty);
   // R11: the flush commands leave both rings empty
   a_r11_cmd_flush: assert property (@(posedge clk) disable iff (!rst_n)
      do_reset |=> rx_empty && tx_empty);
   // R9: an accepted frame raises the receive flag
   a_r9_commit_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rx_commit |=> istat[0] && !rx_empty);
   // R5: a sent enqueue raises both transmit flags
   a_r5_send_flags: assert property (@(posedge clk) disable iff (!rst_n)
      enq_send |=> istat[1] && istat[2]);
endmodule

// File: tb/pktbuf_mmu_tb_top.sv
module pktbuf_mmu_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_sel = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_hi_en = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        link_up = 1'b1;
   logic        irq;
   logic        rx_valid = 1'b0, rx_last = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        tx_valid, tx_last;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b0;

   int n_chk = 0, n_bad = 0;
   int ncap = 0, nhold_bad = 0, tick = 0;
   logic [7:0] cap [64];
   logic       cap_last [64];
   logic       prev_stall = 1'b0;
   logic [7:0] prev_data = '0;
   logic       rdy_all = 1'b1;
   logic [15:0] rv;

   always #4 clk = ~clk;

   pktbuf_mmu dut_i (.*);

   // transmit sink: drive ready, then sample the stream later in the same half cycle
   always @(negedge clk) begin
      tick++;
      tx_ready = rdy_all ? 1'b1 : (tick % 3 != 0);
      #1;
      if (prev_stall && !(tx_valid && tx_data == prev_data)) nhold_bad++;
      if (tx_valid && tx_ready && ncap < 64) begin
         cap[ncap] = tx_data;
         cap_last[ncap] = tx_last;
         ncap++;
      end
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] s, input logic [15:0] d, input logic hi = 1'b1);
      @(negedge clk);
      bus_sel = s; bus_wdata = d; bus_hi_en = hi; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] s, output logic [15:0] d, input logic hi = 1'b1);
      @(negedge clk);
      bus_sel = s; bus_hi_en = hi; bus_rd = 1'b1;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic expect_reg(input logic [3:0] s, input logic [15:0] mask,
                             input logic [15:0] exp, input string tag);
      logic [15:0] v;
      rd(s, v);
      chk((v & mask) == exp, tag, int'(v & mask), int'(exp));
   endtask

   // dest kind: 0 station, 1 broadcast, 2 other
   task automatic rx_frame(input int n, input int kind);
      logic [7:0] st [6] = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         rx_valid = 1'b1;
         rx_last  = (k == n - 1);
         if (k < 6) rx_data = (kind == 1) ? 8'hFF : (kind == 2 && k == 5) ? 8'h56 : st[k];
         else       rx_data = 8'(8'h60 + k);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0;
   endtask

   function automatic logic [7:0] txb(input int k, input int raw, input bit odd, input bit bc);
      if (k == 2) return 8'(raw);
      if (k == 3) return 8'(raw >> 8);
      if (k < 4) return 8'h00;
      if (k < 10) return bc ? 8'hFF : 8'(8'h10 + k);
      if (k == raw - 1) return odd ? 8'h20 : 8'h00;
      return 8'(8'hA0 + k);
   endfunction

   task automatic build_tx(input int raw, input bit odd, input bit bc);
      wr(4'd0, 16'h0000);
      for (int k = 0; k < raw; k += 2)
         wr(4'd1, {txb(k + 1, raw, odd, bc), txb(k, raw, odd, bc)});
   endtask

   task automatic t_reset;
      chk(irq == 1'b0, "R13 irq after reset", irq, 0);
      chk(tx_valid == 1'b0, "R13 tx_valid after reset", tx_valid, 0);
      expect_reg(4'd3, 16'hFFFF, 16'h0000, "R13 istat reset");
      expect_reg(4'd11, 16'hFFFF, 16'h8000, "R13 port reset");
      expect_reg(4'd2, 16'hFFFF, 16'h0000, "R13 alloc number reset");
   endtask

   task automatic t_alloc;
      wr(4'd2, 16'h0020);
      expect_reg(4'd2, 16'hFF00, 16'h0000, "R2 first alloc");
      expect_reg(4'd3, 16'h0008, 16'h0008, "R2 alloc flag");
      wr(4'd2, 16'h0020);
      expect_reg(4'd2, 16'hFF00, 16'h0100, "R2 second alloc");
      wr(4'd3, 16'h00FF);
      wr(4'd2, 16'h0000); wr(4'd2, 16'h0070); wr(4'd2, 16'h00A0); wr(4'd2, 16'h0030);
      expect_reg(4'd3, 16'hFFFF, 16'h0000, "R1 ignored codes istat");
      expect_reg(4'd2, 16'hFF00, 16'h0100, "R1 ignored codes alloc");
      expect_reg(4'd11, 16'hFFFF, 16'h8000, "R1 ignored codes port");
      for (int i = 0; i < 126; i++) wr(4'd2, 16'h0020);
      expect_reg(4'd2, 16'hFF00, 16'h7F00, "R2 alloc 127");
      wr(4'd2, 16'h0020);
      expect_reg(4'd2, 16'hFF00, 16'h0000, "R2 alloc wrap");
   endtask

   task automatic t_ptr;
      wr(4'd0, 16'h0010);
      wr(4'd1, 16'hBEEF, 1'b1);
      wr(4'd1, 16'h7712, 1'b0);
      wr(4'd0, 16'h0010);
      expect_reg(4'd1, 16'hFFFF, 16'hBEEF, "R3 word read");
      rd(4'd1, rv, 1'b0);
      chk(rv == 16'h0012, "R3 low-lane read", rv, 16'h0012);
      expect_reg(4'd0, 16'hFFFF, 16'h0013, "R3 pointer step");
   endtask

   task automatic t_tx;
      wr(4'd5, 16'h0001);
      wr(4'd3, 16'h00FF);
      rdy_all = 1'b0;
      // odd-length frame: L=14, end 13, bytes 4..12
      build_tx(14, 1'b1, 1'b0);
      ncap = 0; nhold_bad = 0;
      wr(4'd2, 16'h00C0);
      repeat (40) @(negedge clk);
      chk(ncap == 9, "R6 odd frame length", ncap, 9);
      for (int k = 0; k < 9; k++)
         chk(cap[k] == txb(k + 4, 14, 1'b1, 1'b0) && cap_last[k] == (k == 8),
             "R6 odd frame byte", cap[k], txb(k + 4, 14, 1'b1, 1'b0));
      chk(nhold_bad == 0, "R6 stall hold", nhold_bad, 0);
      expect_reg(4'd7, 16'hFFFF, 16'h0001, "R5 status unicast");
      expect_reg(4'd3, 16'h0006, 16'h0006, "R5 tx flags");
      expect_reg(4'd11, 16'h0080, 16'h0080, "R5 port bit 7");
      // even-length broadcast frame: L=16, end 14, bytes 4..13
      build_tx(16, 1'b0, 1'b1);
      ncap = 0;
      wr(4'd2, 16'h00C0);
      repeat (40) @(negedge clk);
      chk(ncap == 10, "R6 even frame length", ncap, 10);
      chk(cap[0] == 8'hFF && cap[9] == txb(13, 16, 1'b0, 1'b1), "R6 even frame ends",
          cap[9], txb(13, 16, 1'b0, 1'b1));
      chk(nhold_bad == 0, "R6 stall hold broadcast", nhold_bad, 0);
      expect_reg(4'd7, 16'hFFFF, 16'h0041, "R5 status broadcast");
      rdy_all = 1'b1;
   endtask

   task automatic t_tx_off;
      wr(4'd5, 16'h0000);
      wr(4'd3, 16'h00FF);
      build_tx(14, 1'b1, 1'b0);
      ncap = 0;
      wr(4'd2, 16'h00C0);
      repeat (30) @(negedge clk);
      chk(ncap == 0, "R8 nothing sent", ncap, 0);
      expect_reg(4'd3, 16'hFFFF, 16'h0000, "R8 istat unchanged");
      expect_reg(4'd7, 16'hFFFF, 16'h0041, "R8 status unchanged");
   endtask

   task automatic t_rx;
      wr(4'd8, 16'h1102); wr(4'd9, 16'h3322); wr(4'd10, 16'h5544);
      wr(4'd6, 16'h0100);
      wr(4'd3, 16'h00FF);
      rx_frame(8, 2);
      expect_reg(4'd11, 16'h8000, 16'h8000, "R9 mismatch dropped");
      expect_reg(4'd3, 16'h0001, 16'h0000, "R9 mismatch no flag");
      rx_frame(5, 1);
      expect_reg(4'd11, 16'h8000, 16'h8000, "R9 short frame dropped");
      rx_frame(8, 1);
      expect_reg(4'd3, 16'h0001, 16'h0001, "R9 broadcast flag");
      expect_reg(4'd11, 16'h8000, 16'h0000, "R4 port not empty");
      rx_frame(10, 0);
      wr(4'd0, 16'h8002);
      expect_reg(4'd1, 16'hFFFF, 16'h0008, "R9 byte count");
      expect_reg(4'd1, 16'hFFFF, 16'hFFFF, "R9 dest at offset 4");
      wr(4'd0, 16'h8004);
      wr(4'd1, 16'h0000);
      wr(4'd0, 16'h8004);
      expect_reg(4'd1, 16'hFFFF, 16'hFFFF, "R3 receive write dropped");
      wr(4'd2, 16'h0080);
      expect_reg(4'd3, 16'h0001, 16'h0001, "R4 flag kept, frame left");
      wr(4'd0, 16'h8002);
      expect_reg(4'd1, 16'hFFFF, 16'h000A, "R4 next frame count");
      expect_reg(4'd1, 16'hFFFF, 16'h1102, "R9 station frame dest");
      wr(4'd2, 16'h0060);
      expect_reg(4'd3, 16'h0001, 16'h0000, "R4 flag cleared on last");
      expect_reg(4'd11, 16'h8000, 16'h8000, "R4 port empty");
      wr(4'd2, 16'h0080);
      expect_reg(4'd11, 16'h8000, 16'h8000, "R4 remove on empty");
      expect_reg(4'd3, 16'h0001, 16'h0000, "R4 remove on empty flag");
   endtask

   task automatic t_full;
      int cnt = 0;
      for (int i = 0; i < 16; i++) rx_frame(6, 1);
      for (int i = 0; i < 20; i++) begin
         rd(4'd11, rv);
         if (rv[15]) break;
         wr(4'd2, 16'h0080);
         cnt++;
      end
      chk(cnt == 15, "R10 ring capacity", cnt, 15);
   endtask

   task automatic t_flush;
      rx_frame(6, 1); rx_frame(6, 1);
      wr(4'd6, 16'h0000);
      expect_reg(4'd11, 16'h8000, 16'h8000, "R11 receive disable flush");
      wr(4'd6, 16'h0100);
      rx_frame(6, 1);
      wr(4'd2, 16'h0040);
      expect_reg(4'd11, 16'h8000, 16'h8000, "R11 reset MMU flush");
      rx_frame(6, 1);
      wr(4'd2, 16'h00E0);
      expect_reg(4'd11, 16'h8000, 16'h8000, "R11 reset FIFO flush");
      rx_frame(6, 1);
      wr(4'd6, 16'h8100);
      expect_reg(4'd11, 16'h8000, 16'h8000, "R11 control bit 15 flush");
      wr(4'd6, 16'h0100);
      rx_frame(6, 0);
      expect_reg(4'd11, 16'h8000, 16'h0000, "R11 ring usable after flush");
   endtask

   task automatic t_link_down;
      wr(4'd5, 16'h1401);
      link_up = 1'b0;
      wr(4'd2, 16'h00C0);
      expect_reg(4'd7, 16'hFFFF, 16'h0461, "R7 error status bits");
      expect_reg(4'd5, 16'hFFFF, 16'h1400, "R7 transmit enable cleared");
      expect_reg(4'd3, 16'h0022, 16'h0020, "R7 interrupt flags");
      expect_reg(4'd11, 16'h8000, 16'h8000, "R7 receive ring flushed");
      link_up = 1'b1;
   endtask

   task automatic t_irq;
      wr(4'd4, 16'h0020);
      @(negedge clk);
      chk(irq == 1'b1, "R12 masked flag drives irq", irq, 1);
      wr(4'd4, 16'h0010);
      @(negedge clk);
      chk(irq == 1'b0, "R12 unmasked flag quiet", irq, 0);
      wr(4'd3, 16'h00FF);
      expect_reg(4'd3, 16'hFFFF, 16'h0000, "R13 write-one clear");
      wr(4'd4, 16'h0020);
      @(negedge clk);
      chk(irq == 1'b0, "R12 irq after clear", irq, 0);
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0x1 expected=0x0");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_alloc();
      t_ptr();
      t_tx();
      t_tx_off();
      t_rx();
      t_full();
      t_flush();
      t_link_down();
      t_irq();
      summary();
   end
endmodule